// File: doc/BRIEF.md
# PCI Error Signalling Control with First-Error Capture

This block decides how error events seen by a PCI bridge reach the system. Each clock it receives single-cycle event strobes for five conditions: an address parity error, a data parity error on an inbound transaction, a data parity error on an outbound transaction, an observed PERR#, and an inbound read discard-timer expiry. It combines these strobes with two enables taken from the standard PCI command register, the SERR# enable and the parity-error-response enable. It also uses its own 16-bit command register. From these inputs it drives an active-low system error strobe and a mirror copy of that strobe, a one-shot system-init pulse and a level interrupt request.

An 8-bit status register records the first error event only. Once any bit in it is set, all later events are ignored until software clears every bit by writing ones. The status register keeps its contents through a warm reset, and only the cold reset clears it. Software reaches both registers through a byte-wide port. Write data is applied at the clock edge. Read data is registered and returned one cycle after the address is presented.

Top module: `pci_err_ctl`

## Requirements
- R1: Cold reset makes the command register read 0x40 at byte offset 0 and 0x80 at offset 1, and the status register (offset 2) read 0x00. It also sets serr_n and serr_mirror_n to 1, sys_init to 0 and irq to 0. Offset 3 always reads 0x00.
- R2: Command register bits: 15 is the init override, 13 the interrupt enable, 12 the address-parity error enable, 11 the data-parity error enable and 10 the discard-timer error enable. Only these five bits are writable. Bit 6 always reads 1, and all other bits always read 0. reg_rdata shows the byte selected by reg_addr one cycle after the address is presented.
- R3: An address parity strobe drives serr_n and serr_mirror_n low for exactly one clock, in the cycle after the strobe. This happens only when command bit 12, cmd_serr_en and cmd_parity_en are all 1.
- R4: An inbound data parity strobe drives serr_n and serr_mirror_n low for one clock, in the cycle after the strobe, only when command bit 11 and cmd_serr_en are both 1. cmd_parity_en has no effect on this path.
- R5: A discard-timer expiry strobe drives serr_n and serr_mirror_n low for one clock, in the cycle after the strobe, only when command bit 10 and cmd_serr_en are both 1.
- R6: When an event that drives serr_n low arrives while the init override is 0, sys_init goes high for one clock in the same cycle as the serr_n pulse. From that cycle on, the override reads 1. No further init pulse can occur until software writes the override back to 0. If software writes the override in the same cycle that hardware sets it, the hardware set wins.
- R7: Status bit encoding: bit 0 address parity, bit 1 inbound data parity, bit 2 outbound data parity, bit 3 PERR# observed, bit 4 discard-timer expiry. Bits 7:5 read 0. While the register reads zero, every strobe present in a cycle is captured together, whatever the enables. While it is nonzero, strobes have no effect.
- R8: A write to offset 2 clears each status bit written as 1 and leaves bits written as 0 unchanged. If the register is empty, any capture in that same cycle takes priority over the write.
- R9: irq is high from the second cycle after a PERR# or outbound data parity strobe is captured as a first error while command bit 13 is 1. It stays high until software clears that status bit or clears bit 13. It falls one cycle after either write takes effect.
- R10: A warm reset restores the command register to its reset value and returns serr_n, serr_mirror_n, sys_init and irq to idle. It leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high reset of every register |
| warm_rst | input | 1 | Synchronous active-high reset that spares the status register |
| reg_addr | input | ADDR_W (2) | Byte offset for reads and writes |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | DW (8) | Write data byte |
| reg_rdata | output | DW (8) | Registered read data |
| cmd_serr_en | input | 1 | SERR# enable from the PCI command register |
| cmd_parity_en | input | 1 | Parity error response enable from the PCI command register |
| ev_addr_par | input | 1 | Address parity error strobe |
| ev_in_data_par | input | 1 | Inbound data parity error strobe |
| ev_out_data_par | input | 1 | Outbound data parity error strobe |
| ev_perr_seen | input | 1 | Observed PERR# strobe |
| ev_discard_exp | input | 1 | Inbound read discard-timer expiry strobe |
| serr_n | output | 1 | Active-low system error strobe |
| serr_mirror_n | output | 1 | Copy of serr_n for the system-side pin |
| sys_init | output | 1 | One-shot system-init pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A capture register stuck nonzero, or failing to hold, shows up at the next status read. It also shows as an interrupt that rises for the wrong first error, two cycles after the strobe. A wrong enable gate shows up within one cycle as a missing or extra low cycle on serr_n. The bench sweeps every combination of source enable, SERR# enable and parity enable for all three sources, and all 32 strobe patterns for capture. An override bit that fails to set itself appears as a second sys_init pulse on the next qualifying event.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;
  localparam int EVT_N      = 5;
  localparam int EV_ADDR    = 0;
  localparam int EV_IN_DATA = 1;
  localparam int EV_OUT_DAT = 2;
  localparam int EV_PERR    = 3;
  localparam int EV_DISCARD = 4;

  localparam int CB_OVR  = 15;
  localparam int CB_IRQ  = 13;
  localparam int CB_ADDR = 12;
  localparam int CB_DATA = 11;
  localparam int CB_DISC = 10;

  localparam logic [15:0] CMD_RST   = 16'h8040;
  localparam logic [15:0] CMD_WMASK = 16'hBC00;
endpackage

// File: rtl/err_cmd_reg.sv
module err_cmd_reg
  import pci_err_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              hw_set_ovr,
  output logic [CMD_W-1:0]  cmd_q
);
  localparam int NBYTES = CMD_W / DW;
  localparam logic [CMD_W-1:0] OVR_BIT = CMD_W'(1) << CB_OVR;
  localparam logic [CMD_W-1:0] RSTV    = CMD_W'(CMD_RST);
  localparam logic [CMD_W-1:0] WMASK   = CMD_W'(CMD_WMASK);

  logic [CMD_W-1:0] set_vec;
  assign set_vec = hw_set_ovr ? OVR_BIT : '0;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (cold_rst || warm_rst) begin
        cmd_q[b*DW +: DW] <= RSTV[b*DW +: DW];
      end else if (wr_en && wr_addr == ADDR_W'(b)) begin
        cmd_q[b*DW +: DW] <= (wr_data & WMASK[b*DW +: DW])
                           | (RSTV[b*DW +: DW] & ~WMASK[b*DW +: DW])
                           | set_vec[b*DW +: DW];
      end else begin
        cmd_q[b*DW +: DW] <= cmd_q[b*DW +: DW] | set_vec[b*DW +: DW];
      end
    end
  end

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (cold_rst)
    hw_set_ovr |=> cmd_q[CB_OVR]);
endmodule

// File: rtl/err_first_capture.sv
module err_first_capture
  import pci_err_pkg::*;
#(
  parameter int ST_W = 8
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic [EVT_N-1:0] evt,
  input  logic             clr_en,
  input  logic [ST_W-1:0]  clr_mask,
  output logic [ST_W-1:0]  st_q
);
  localparam int PAD = ST_W - EVT_N;

  logic empty;
  assign empty = (st_q == '0);

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      st_q <= '0;
    end else if (empty) begin
      st_q <= {{PAD{1'b0}}, evt};
    end else if (clr_en) begin
      st_q <= st_q & ~clr_mask;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (st_q != '0 && !clr_en) |=> st_q == $past(st_q));
  // R7
  capture_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (st_q == '0) |=> st_q[EVT_N-1:0] == $past(evt));
  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (st_q != '0 && clr_en) |=> st_q == ($past(st_q) & ~$past(clr_mask)));
endmodule

// File: rtl/err_signal_gen.sv
module err_signal_gen
  import pci_err_pkg::*;
#(
  parameter int CMD_W = 16,
  parameter int ST_W  = 8
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             warm_rst,
  input  logic [EVT_N-1:0] evt,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic [ST_W-1:0]  st_q,
  input  logic             serr_en,
  input  logic             parity_en,
  output logic             set_ovr,
  output logic             serr_n,
  output logic             serr_mirror_n,
  output logic             init_o,
  output logic             irq_o
);
  logic q_addr, q_data, q_disc, qual, irq_nxt;

  assign q_addr  = evt[EV_ADDR]    && cmd_q[CB_ADDR] && serr_en && parity_en;
  assign q_data  = evt[EV_IN_DATA] && cmd_q[CB_DATA] && serr_en;
  assign q_disc  = evt[EV_DISCARD] && cmd_q[CB_DISC] && serr_en;
  assign qual    = q_addr || q_data || q_disc;
  assign set_ovr = qual && !cmd_q[CB_OVR] && !warm_rst;
  assign irq_nxt = cmd_q[CB_IRQ] && (st_q[EV_OUT_DAT] || st_q[EV_PERR]);

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) begin
      serr_n        <= 1'b1;
      serr_mirror_n <= 1'b1;
      init_o        <= 1'b0;
      irq_o         <= 1'b0;
    end else begin
      serr_n        <= !qual;
      serr_mirror_n <= !qual;
      init_o        <= set_ovr;
      irq_o         <= irq_nxt;
    end
  end

  // R3
  serr_src_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    !serr_n |-> ($past(serr_en) && $past(evt[EV_ADDR] || evt[EV_IN_DATA] || evt[EV_DISCARD])));
  // R6
  init_once_chk: assert property (@(posedge clk) disable iff (cold_rst)
    init_o |=> !init_o);
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    irq_o |-> $past(st_q[EV_OUT_DAT] || st_q[EV_PERR]));
endmodule

// File: rtl/pci_err_ctl.sv
module pci_err_ctl
  import pci_err_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              cmd_serr_en,
  input  logic              cmd_parity_en,
  input  logic              ev_addr_par,
  input  logic              ev_in_data_par,
  input  logic              ev_out_data_par,
  input  logic              ev_perr_seen,
  input  logic              ev_discard_exp,
  output logic              serr_n,
  output logic              serr_mirror_n,
  output logic              sys_init,
  output logic              irq
);
  localparam int NBYTES   = CMD_W / DW;
  localparam int STAT_OFS = NBYTES;

  logic [EVT_N-1:0] evt;
  logic [CMD_W-1:0] cmd_q;
  logic [DW-1:0]    st_q;
  logic             set_ovr, clr_en;
  logic [DW-1:0]    rd_nxt;

  assign evt = {ev_discard_exp, ev_perr_seen, ev_out_data_par, ev_in_data_par, ev_addr_par};
  assign clr_en = reg_wr && (reg_addr == ADDR_W'(STAT_OFS));

  err_cmd_reg #(.DW(DW), .CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .hw_set_ovr(set_ovr), .cmd_q(cmd_q)
  );

  err_first_capture #(.ST_W(DW)) u_cap (
    .clk(clk), .cold_rst(cold_rst), .evt(evt),
    .clr_en(clr_en), .clr_mask(reg_wdata), .st_q(st_q)
  );

  err_signal_gen #(.CMD_W(CMD_W), .ST_W(DW)) u_sig (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .evt(evt), .cmd_q(cmd_q), .st_q(st_q),
    .serr_en(cmd_serr_en), .parity_en(cmd_parity_en),
    .set_ovr(set_ovr), .serr_n(serr_n), .serr_mirror_n(serr_mirror_n),
    .init_o(sys_init), .irq_o(irq)
  );

  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (reg_addr == ADDR_W'(b)) rd_nxt = cmd_q[b*DW +: DW];
    end
    if (reg_addr == ADDR_W'(STAT_OFS)) rd_nxt = st_q;
  end

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) reg_rdata <= '0;
    else                      reg_rdata <= rd_nxt;
  end

  // R10
  warm_keep_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (warm_rst && st_q != '0 && !clr_en) |=> st_q == $past(st_q));
endmodule

// File: tb/tb_pci_err_ctl.sv
module tb_pci_err_ctl;
  logic       clk = 1'b0;
  logic       cold_rst = 1'b1, warm_rst = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       serr_en = 1'b0, par_en = 1'b0;
  logic [4:0] ev = '0;
  logic       serr_n, serr_mirror_n, sys_init, irq;
  int         total = 0, fails = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  pci_err_ctl dut (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_serr_en(serr_en), .cmd_parity_en(par_en),
    .ev_addr_par(ev[0]), .ev_in_data_par(ev[1]), .ev_out_data_par(ev[2]),
    .ev_perr_seen(ev[3]), .ev_discard_exp(ev[4]),
    .serr_n(serr_n), .serr_mirror_n(serr_mirror_n), .sys_init(sys_init), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b0;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic fire(input logic [4:0] p);
    @(negedge clk); ev = p;
    @(negedge clk); ev = '0;
  endtask

  task automatic clr_st();
    wr(2'd2, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    cold_rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 serr_n", serr_n, 1);
    check("R1 mirror", serr_mirror_n, 1);
    check("R1 init", sys_init, 0);
    check("R1 irq", irq, 0);
    rd(2'd0, d); check("R1 cmd lo", d, 8'h40);
    rd(2'd1, d); check("R1 cmd hi", d, 8'h80);
    rd(2'd2, d); check("R1 status", d, 8'h00);
    rd(2'd3, d); check("R1 unused ofs", d, 8'h00);

    // R2 writable and fixed bits
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R2 lo all ones", d, 8'h40);
    wr(2'd0, 8'h00); rd(2'd0, d); check("R2 lo zeros", d, 8'h40);
    wr(2'd1, 8'hFF); rd(2'd1, d); check("R2 hi all ones", d, 8'hBC);
    wr(2'd1, 8'h00); rd(2'd1, d); check("R2 hi zeros", d, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R2 ofs3", d, 8'h00);
    wr(2'd1, 8'h80);

    // R3 R4 R5 exhaustive enable sweep per source
    for (int src = 0; src < 3; src++) begin
      for (int c = 0; c < 8; c++) begin
        logic [4:0] evb;
        logic [7:0] hi;
        logic       exp_low;
        string      tag;
        evb = (src == 0) ? 5'b00001 : (src == 1) ? 5'b00010 : 5'b10000;
        hi  = 8'h80 | ((c & 1) ? ((src == 0) ? 8'h10 : (src == 1) ? 8'h08 : 8'h04) : 8'h00);
        tag = (src == 0) ? "R3" : (src == 1) ? "R4" : "R5";
        if (src == 0) exp_low = c[0] && c[1] && c[2];
        else          exp_low = c[0] && c[1];
        wr(2'd1, hi);
        clr_st();
        serr_en = c[1]; par_en = c[2];
        @(negedge clk); ev = evb;
        @(negedge clk); ev = '0;
        check({tag, " serr_n pulse"}, serr_n, !exp_low);
        check({tag, " mirror pulse"}, serr_mirror_n, !exp_low);
        check({tag, " no init with override"}, sys_init, 0);
        tick();
        check({tag, " one clock"}, serr_n, 1);
      end
    end
    serr_en = 0; par_en = 0;
    wr(2'd1, 8'h80);

    // R7 capture all 32 patterns
    for (int p = 0; p < 32; p++) begin
      clr_st();
      fire(5'(p));
      rd(2'd2, d);
      check("R7 capture pattern", d, 8'(p));
    end
    clr_st();
    fire(5'b01001);
    fire(5'b10000);
    rd(2'd2, d); check("R7 later event ignored", d, 8'h09);

    // R8 write-1-to-clear
    wr(2'd2, 8'h01); rd(2'd2, d); check("R8 clear bit0", d, 8'h08);
    wr(2'd2, 8'h00); rd(2'd2, d); check("R8 zero write", d, 8'h08);
    wr(2'd2, 8'h08); rd(2'd2, d); check("R8 clear rest", d, 8'h00);
    fire(5'b00100); rd(2'd2, d); check("R8 recapture", d, 8'h04);
    clr_st();
    @(negedge clk); ev = 5'b00010; reg_addr = 2'd2; reg_wdata = 8'hFF; reg_wr = 1'b1;
    @(negedge clk); ev = '0; reg_wr = 1'b0;
    rd(2'd2, d); check("R8 capture beats clear", d, 8'h02);
    clr_st();

    // R6 init one-shot
    serr_en = 1;
    wr(2'd1, 8'h00); clr_st();
    fire(5'b00010);
    check("R6 no init unqualified", sys_init, 0);
    rd(2'd1, d); check("R6 override stays 0", d, 8'h00);
    wr(2'd1, 8'h08); clr_st();
    fire(5'b00010);
    check("R6 init pulse", sys_init, 1);
    check("R6 serr with init", serr_n, 0);
    tick();
    check("R6 init one clock", sys_init, 0);
    rd(2'd1, d); check("R6 override set", d, 8'h88);
    clr_st();
    fire(5'b00010);
    check("R6 serr again", serr_n, 0);
    check("R6 no repeat init", sys_init, 0);
    wr(2'd1, 8'h08); clr_st();
    @(negedge clk); ev = 5'b00010; reg_addr = 2'd1; reg_wdata = 8'h08; reg_wr = 1'b1;
    @(negedge clk); ev = '0; reg_wr = 1'b0;
    check("R6 init during write", sys_init, 1);
    rd(2'd1, d); check("R6 hw set wins", d, 8'h88);
    serr_en = 0;

    // R9 interrupt
    wr(2'd1, 8'hA0); clr_st();
    fire(5'b01000);
    check("R9 irq not yet", irq, 0);
    tick();
    check("R9 irq perr", irq, 1);
    repeat (3) tick();
    check("R9 irq held", irq, 1);
    wr(2'd2, 8'h08);
    check("R9 irq before drop", irq, 1);
    tick();
    check("R9 irq cleared", irq, 0);
    fire(5'b00100); tick();
    check("R9 irq outbound", irq, 1);
    wr(2'd1, 8'h80); tick();
    check("R9 irq enable off", irq, 0);
    wr(2'd1, 8'hA0); clr_st();
    fire(5'b00001); fire(5'b01000); tick(); tick();
    check("R9 no irq other first", irq, 0);
    clr_st();

    // R10 warm reset
    wr(2'd1, 8'hA0); clr_st();
    fire(5'b01000); tick();
    check("R10 irq before warm", irq, 1);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    check("R10 irq idle", irq, 0);
    check("R10 serr idle", serr_n, 1);
    rd(2'd2, d); check("R10 status kept", d, 8'h08);
    rd(2'd1, d); check("R10 cmd hi default", d, 8'h80);
    rd(2'd0, d); check("R10 cmd lo default", d, 8'h40);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule